// File: doc/BRIEF.md
# Six-Step Sensorless Commutation Sequencer

This block sequences a three-phase brushless motor bridge through six commutation steps. It holds a step index from 0 to 5. For each phase (A, B, C) it produces a PWM gate signal and a driver-enable signal. In every step, one phase carries the PWM waveform, one is held low with its driver on, and one floats with its driver off. The floating phase is the one routed to the back-EMF comparator. The block reports which phase that is and which comparator edge (rising or falling) counts as a zero crossing in the current step.

A controller outside the block decides when to commutate and pulses `advance_i`. The sequencer then moves to the next step in three ordered sub-steps:
1. It removes the enable of the phase that is about to float.
2. It changes the PWM routing.
3. It enables the newly driven phase.

A commutation interval timer restarts on every step advance. The raw comparator output is synchronised, and edges of the expected polarity produce a one-cycle zero-crossing pulse. Detection is masked while an analog sample is being taken on the shared multiplexer.

A duty value of zero is an active brake, not a coast. The block first turns all drivers off and detaches PWM. It then turns all three drivers on with their gates low, so all low sides conduct. When the duty becomes non-zero again, the current step is re-entered through the same ordered sequence, and the step index does not change.

Top module: `bldc_six_step_seq`

## Requirements
- R1: While `rst_n` is low, and for two rising edges after it rises, the outputs are as follows: `step_o`=0, `drv_en_o`=0, `gate_pwm_o`=0, `comm_timer_o`=0 and `zc_pulse_o`=0.
- R2: Each accepted advance raises `step_o` by one modulo 6, so step 5 is followed by step 0.
- R3: Bit 0 is phase A, bit 1 is phase B and bit 2 is phase C. Once a transition has settled, the drivers are as follows:
  - The PWM phase is A on steps 0 and 5, C on steps 1 and 2, and B on steps 3 and 4.
  - The sensed phase is C on steps 0 and 3, A on steps 1 and 4, and B on steps 2 and 5.
  - `drv_en_o` is set for the two non-sensed phases.
  - `gate_pwm_o` is routed only to the PWM phase.
- R4: `sense_sel_o` codes the sensed phase as A=0, B=1, C=2. `edge_rise_o` is 1 on odd steps (rising edge expected) and 0 on even steps (falling edge expected).
- R5: `step_o` and the timer change on the edge that accepts an advance. On the next edge, the new sensed phase's enable is cleared. On the edge after that, the PWM routing changes. On the third edge after acceptance, the enables become the new step's driven set.
- R6: Advance strobes that arrive while a transition or brake is in progress are held as a single pending advance. That pending advance is accepted on the first idle cycle with a non-zero duty, and several held strobes collapse into one.
- R7: `comm_timer_o` clears to 0 on the edge that accepts an advance. On every other edge it increments, saturating at 65535.
- R8: An 8-bit counter starts at 0 after reset and advances every cycle. A PWM-routed phase's gate is high while the counter is below `duty_i`. Every other gate is 0.
- R9: If `duty_i`=0 in an idle cycle, the block brakes, and the brake takes priority over a pending or same-cycle advance. On the next edge, all enables and all PWM routing are cleared. On the edge after that, all three enables are set with no PWM. This state holds until the duty becomes non-zero. The current step is then re-entered through the R5 order without incrementing, and the timer is not cleared.
- R10: `cmp_raw_i` passes through two synchronising flops. `zc_pulse_o` is high for the cycle after the synchronised value shows an edge of the polarity selected by `edge_rise_o`. An edge of the other polarity produces no pulse.
- R11: `zc_pulse_o` is 0 whenever `sample_req_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| duty_i | input | 8 | PWM compare level shared by all phases; 0 means brake |
| advance_i | input | 1 | One-cycle request to commutate to the next step |
| cmp_raw_i | input | 1 | Unsynchronised back-EMF comparator output |
| sample_req_i | input | 1 | High while an analog sample occupies the comparator multiplexer |
| gate_pwm_o | output | 3 | PWM gate per phase (bit 0 A, bit 1 B, bit 2 C) |
| drv_en_o | output | 3 | Driver enable per phase (bit 0 A, bit 1 B, bit 2 C) |
| sense_sel_o | output | 2 | Sensed phase code: 0 A, 1 B, 2 C |
| edge_rise_o | output | 1 | 1 when a rising zero crossing is expected, 0 for falling |
| zc_pulse_o | output | 1 | One-cycle zero-crossing event |
| comm_timer_o | output | 16 | Cycles since the last accepted advance, saturating |
| step_o | output | 3 | Current commutation step 0..5 |

## Verification
Two pairs of functions can coincide in one cycle. The first is an advance strobe and a zero duty arriving in the same idle cycle, where the brake must win and the advance must survive as a pending request. The second is a synchronised comparator edge that lands on the very edge where the step index changes, so it must be judged against the new step's polarity. The bench drives the first case directly, by setting the duty to zero and pulsing advance together. It reaches the second case, and overlaps of advances with ongoing transitions, through a stretch of random strobes, comparator flips, sample requests and zero duties. In both cases a behavioural model of the step table, the pending flag, the brake order and the synchroniser history is compared with every output on every cycle.

// File: rtl/bldc_seq_pkg.sv
package bldc_seq_pkg;

  localparam int NPH = 3;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CUT      = 3'd1,
    ST_ROUTE    = 3'd2,
    ST_DRIVE    = 3'd3,
    ST_BRK_CUT  = 3'd4,
    ST_BRK_LOW  = 3'd5,
    ST_BRK_HOLD = 3'd6
  } seq_state_e;

  // Floating phase per step: 0 = A, 1 = B, 2 = C
  function automatic logic [1:0] step_sense_code(input logic [2:0] s);
    logic [1:0] c;
    case (s)
      3'd1, 3'd4: c = 2'd0;
      3'd2, 3'd5: c = 2'd1;
      default:    c = 2'd2;
    endcase
    return c;
  endfunction

  function automatic logic [NPH-1:0] step_sense_mask(input logic [2:0] s);
    return NPH'(1) << step_sense_code(s);
  endfunction

  // Phase carrying the PWM waveform per step
  function automatic logic [NPH-1:0] step_pwm_mask(input logic [2:0] s);
    logic [NPH-1:0] m;
    case (s)
      3'd1, 3'd2: m = 3'b100;
      3'd3, 3'd4: m = 3'b010;
      default:    m = 3'b001;
    endcase
    return m;
  endfunction

  function automatic logic [2:0] step_next(input logic [2:0] s);
    return (s == 3'd5) ? 3'd0 : s + 3'd1;
  endfunction

endpackage

// File: rtl/bldc_commutation_ctrl.sv
module bldc_commutation_ctrl
  import bldc_seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           duty_zero_i,
  input  logic           advance_i,
  output logic [2:0]     step_o,
  output logic [NPH-1:0] drv_en_o,
  output logic [NPH-1:0] pwm_route_o,
  output logic           step_go_o,
  output logic           settled_o
);

  seq_state_e     state_q, state_d;
  logic [2:0]     step_q, step_d;
  logic [NPH-1:0] en_q, en_d;
  logic [NPH-1:0] route_q, route_d;
  logic           pend_q, pend_d;
  logic           go;
  logic           step_ce, en_ce, route_ce;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    en_d    = en_q;
    route_d = route_q;
    go      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (duty_zero_i) begin
          state_d = ST_BRK_CUT;
        end else if (advance_i || pend_q) begin
          go      = 1'b1;
          step_d  = step_next(step_q);
          state_d = ST_CUT;
        end
      end
      ST_CUT: begin
        en_d    = en_q & ~step_sense_mask(step_q);
        state_d = ST_ROUTE;
      end
      ST_ROUTE: begin
        route_d = step_pwm_mask(step_q);
        state_d = ST_DRIVE;
      end
      ST_DRIVE: begin
        en_d    = ~step_sense_mask(step_q);
        state_d = ST_IDLE;
      end
      ST_BRK_CUT: begin
        en_d    = '0;
        route_d = '0;
        state_d = ST_BRK_LOW;
      end
      ST_BRK_LOW: begin
        en_d    = '1;
        state_d = ST_BRK_HOLD;
      end
      ST_BRK_HOLD: begin
        if (!duty_zero_i) state_d = ST_CUT;
      end
      default: state_d = ST_IDLE;
    endcase
    pend_d   = go ? 1'b0 : (pend_q | advance_i);
    step_ce  = go;
    en_ce    = (en_d != en_q);
    route_ce = (route_d != route_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= 3'd0;
      en_q    <= '0;
      route_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      if (step_ce)  step_q  <= step_d;
      if (en_ce)    en_q    <= en_d;
      if (route_ce) route_q <= route_d;
    end
  end

  assign step_o      = step_q;
  assign drv_en_o    = en_q;
  assign pwm_route_o = route_q;
  assign step_go_o   = go;
  assign settled_o   = (state_q == ST_IDLE);

  assert_step_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= 3'd5);

  assert_sense_floats_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> ((en_q & step_sense_mask(step_q)) == '0));

  assert_cut_before_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ROUTE) |-> ((en_q & step_sense_mask(step_q)) == '0));

  assert_route_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ROUTE) |=> $stable(en_q));

  assert_enables_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CUT || state_q == ST_DRIVE) |=> $stable(route_q));

  assert_brake_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BRK_HOLD) |-> (en_q == '1 && route_q == '0));

endmodule

// File: rtl/bldc_pwm_gen.sv
module bldc_pwm_gen
  import bldc_seq_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [NPH-1:0]    route_i,
  output logic [NPH-1:0]    gate_o
);

  logic [DUTY_W-1:0] cnt_q, cnt_d;
  logic              on_phase;

  always_comb begin
    cnt_d    = cnt_q + 1'b1;
    on_phase = (cnt_q < duty_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar p = 0; p < NPH; p++) begin : g_gate
    assign gate_o[p] = route_i[p] & on_phase;
  end

endmodule

// File: rtl/bldc_zc_detect.sv
module bldc_zc_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_raw_i,
  input  logic expect_rise_i,
  input  logic sample_req_i,
  output logic zc_o
);

  localparam int HW = SYNC_STAGES + 1;

  logic [HW-1:0] hist_q;
  logic          cur, prev, rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= {hist_q[HW-2:0], cmp_raw_i};
  end

  always_comb begin
    cur  = hist_q[SYNC_STAGES-1];
    prev = hist_q[SYNC_STAGES];
    rise = cur & ~prev;
    fall = ~cur & prev;
    zc_o = ~sample_req_i & (expect_rise_i ? rise : fall);
  end

endmodule

// File: rtl/bldc_comm_timer.sv
module bldc_comm_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  output logic [TMR_W-1:0] cnt_o
);

  localparam logic [TMR_W-1:0] TMR_MAX = '1;

  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = clr_i || (cnt_q != TMR_MAX);
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_tmr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  assert_tmr_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && cnt_q == TMR_MAX) |=> (cnt_q == TMR_MAX));

endmodule

// File: rtl/bldc_six_step_seq.sv
module bldc_six_step_seq
  import bldc_seq_pkg::*;
#(
  parameter int DUTY_W      = 8,
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              advance_i,
  input  logic              cmp_raw_i,
  input  logic              sample_req_i,
  output logic [2:0]        gate_pwm_o,
  output logic [2:0]        drv_en_o,
  output logic [1:0]        sense_sel_o,
  output logic              edge_rise_o,
  output logic              zc_pulse_o,
  output logic [TMR_W-1:0]  comm_timer_o,
  output logic [2:0]        step_o
);

  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic [NPH-1:0] route;
  logic           step_go;
  logic           settled;
  logic [2:0]     step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bldc_commutation_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .duty_zero_i(duty_i == '0),
    .advance_i  (advance_i),
    .step_o     (step),
    .drv_en_o   (drv_en_o),
    .pwm_route_o(route),
    .step_go_o  (step_go),
    .settled_o  (settled)
  );

  bldc_pwm_gen #(.DUTY_W(DUTY_W)) u_pwm (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .duty_i (duty_i),
    .route_i(route),
    .gate_o (gate_pwm_o)
  );

  bldc_zc_detect #(.SYNC_STAGES(SYNC_STAGES)) u_zc (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cmp_raw_i    (cmp_raw_i),
    .expect_rise_i(step[0]),
    .sample_req_i (sample_req_i),
    .zc_o         (zc_pulse_o)
  );

  bldc_comm_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk  (clk),
    .rst_n(rst_int_n),
    .clr_i(step_go),
    .cnt_o(comm_timer_o)
  );

  assign step_o      = step;
  assign sense_sel_o = step_sense_code(step);
  assign edge_rise_o = step[0];

  assert_gate_on_enabled_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    settled |-> ((gate_pwm_o & ~drv_en_o) == '0));

  assert_zc_masked_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    sample_req_i |-> !zc_pulse_o);

  assert_timer_restart_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step_o != $past(step_o)) |-> (comm_timer_o == '0));

endmodule

// File: tb/bldc_six_step_seq_tb.sv
module bldc_six_step_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  duty;
  logic        adv, cmp, samp;
  logic [2:0]  gate, en, step;
  logic [1:0]  ssel;
  logic        erise, zc;
  logic [15:0] tmr;

  always #10 clk = ~clk;

  bldc_six_step_seq u_dut (
    .clk(clk), .rst_n(rst_n), .duty_i(duty), .advance_i(adv),
    .cmp_raw_i(cmp), .sample_req_i(samp), .gate_pwm_o(gate),
    .drv_en_o(en), .sense_sel_o(ssel), .edge_rise_o(erise),
    .zc_pulse_o(zc), .comm_timer_o(tmr), .step_o(step)
  );

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit    done = 0;

  // behavioural reference state
  int       m_step, m_mode, m_cnt, m_tmr;
  bit [2:0] m_en, m_pwm;
  bit       m_pend, m_s1, m_s2, m_s3;
  localparam int IDLE = 0, T1 = 1, T2 = 2, T3 = 3, BOFF = 4, BON = 5, HOLD = 6;

  function automatic int sense_of(int s);
    if (s == 1 || s == 4) return 0;
    if (s == 2 || s == 5) return 1;
    return 2;
  endfunction

  function automatic int pwm_of(int s);
    if (s == 0 || s == 5) return 0;
    if (s == 1 || s == 2) return 2;
    return 1;
  endfunction

  task automatic chk(string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_step = 0; m_mode = IDLE; m_cnt = 0; m_tmr = 0;
    m_en = 0; m_pwm = 0; m_pend = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
  endtask

  task automatic model_step();
    bit go = 0;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = cmp;
    m_cnt = (m_cnt + 1) % 256;
    case (m_mode)
      IDLE: if (duty == 0) m_mode = BOFF;
            else if (adv || m_pend) begin
              go = 1; m_step = (m_step + 1) % 6; m_mode = T1;
            end
      T1:   begin m_en = m_en & ~(3'b001 << sense_of(m_step)); m_mode = T2; end
      T2:   begin m_pwm = 3'b001 << pwm_of(m_step); m_mode = T3; end
      T3:   begin m_en = ~(3'b001 << sense_of(m_step)); m_mode = IDLE; end
      BOFF: begin m_en = 0; m_pwm = 0; m_mode = BON; end
      BON:  begin m_en = 3'b111; m_mode = HOLD; end
      default: if (duty != 0) m_mode = T1;
    endcase
    m_pend = go ? 1'b0 : (m_pend | adv);
    m_tmr  = go ? 0 : ((m_tmr == 65535) ? 65535 : m_tmr + 1);
  endtask

  task automatic compare_all();
    bit exp_zc;
    exp_zc = !samp && ((m_step % 2 == 1) ? (m_s2 && !m_s3) : (!m_s2 && m_s3));
    chk("step", step, m_step);
    chk("drv_en", en, m_en);
    chk("gate", gate, (m_cnt < duty) ? m_pwm : 3'b000);
    chk("sense_sel", ssel, sense_of(m_step));
    chk("edge_rise", erise, m_step % 2);
    chk("zc_pulse", zc, exp_zc);
    chk("timer", tmr, m_tmr);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_adv();
    adv = 1; tick(); adv = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; duty = 8'd100; adv = 0; cmp = 0; samp = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1";
    chk("reset step", step, 0);
    chk("reset drv_en", en, 0);
    chk("reset gate", gate, 0);
    chk("reset timer", tmr, 0);
    chk("reset zc", zc, 0);
    rst_n = 1;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); @(negedge clk);
      compare_all();
    end

    // first commutation, each sub-step on its own edge
    tag = "R5"; pulse_adv(); run(5);
    // PWM compare at several duties (step 1: C carries PWM)
    tag = "R8"; run(520);
    duty = 8'd1;   run(260);
    duty = 8'd255; run(260);
    duty = 8'd128;
    // walk the whole table including the 5 -> 0 wrap
    tag = "R2 R3 R4";
    for (int k = 0; k < 7; k++) begin pulse_adv(); run(9); end
    // strobes during a transition collapse into one pending advance
    tag = "R6";
    pulse_adv(); pulse_adv(); pulse_adv(); run(12);
    pulse_adv(); run(2); pulse_adv(); run(10);
    // zero-crossing polarity per step
    tag = "R10";
    for (int k = 0; k < 6; k++) begin
      cmp = 1; run(5); cmp = 0; run(5);
      pulse_adv(); run(5);
    end
    // sampling masks detection
    tag = "R11";
    samp = 1;
    for (int k = 0; k < 4; k++) begin cmp = ~cmp; run(4); end
    samp = 0; run(4);
    // brake, with an advance in the same idle cycle and one while held
    tag = "R9";
    duty = 0; pulse_adv(); run(6);
    pulse_adv(); run(4);
    duty = 8'd60; run(12);
    duty = 0; run(5); duty = 8'd200; run(10);
    // saturation of the interval timer
    tag = "R7";
    run(66000);
    chk("timer saturated", tmr, 65535);
    pulse_adv();
    chk("timer cleared", tmr, 0);
    // mixed random stress: coincident edges, strobes, brakes
    tag = "R5 R6 R9 R10";
    for (int i = 0; i < 4000; i++) begin
      adv  = ($urandom % 8) == 0;
      cmp  = (($urandom % 5) == 0) ? ~cmp : cmp;
      samp = ($urandom % 10) == 0;
      if (($urandom % 200) == 0) duty = 0;
      else if (duty == 0 && ($urandom % 6) == 0) duty = 8'($urandom % 255 + 1);
      tick();
    end
    adv = 0; samp = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule